// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Monitor

This block holds the single atomic reservation of one hardware thread. A load-reserve request records the effective address and the access size, and marks the reservation valid. A later store-conditional request is compared against that record. The store goes ahead only when the reservation is still valid and both the address and the access length match exactly. The outcome is returned as a 4-bit condition-field code. That code carries the summary-overflow bit supplied with the request.

Every store-conditional consumes the reservation, whether it wins or loses. A separate clear input lets snoop logic or a context-switch sequence drop the reservation at any time. The reservation state is visible at the ports, so the surrounding pipeline or a debugger can see what is held. Sizes are given as a 2-bit code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes.

Top module: `lrsc_monitor`

## Requirements
- R1: After reset the reservation is invalid, `sc_done`, `st_wen` and `sc_crf` are zero, and a store-conditional issued before any load-reserve fails.
- R2: A load-reserve makes `resv_valid` 1 on the next cycle. It also loads `resv_addr` with the request address and `resv_len` with the length in bytes (size code 0/1/2/3 gives 1/2/4/8).
- R3: `st_wen` is 1 exactly when a store-conditional succeeds. Success needs a valid reservation whose recorded length equals the store length and whose recorded address equals the store address.
- R4: When `sc_done` is 1, `sc_crf` is 4'b0010 on success or 4'b0000 on failure, with `sc_so` ORed into bit 0. When `sc_done` is 0, `sc_crf` is 4'b0000.
- R5: Every store-conditional clears the reservation, whether it succeeds or fails.
- R6: A new load-reserve replaces the address and length of any earlier reservation. A store-conditional to the older address then fails.
- R7: `resv_clr` makes the reservation invalid on the next cycle. If a load-reserve arrives in the same cycle, the load-reserve wins and the reservation is valid.
- R8: `sc_done`, `st_wen` and `sc_crf` are registered. `sc_done` is 1 in exactly the cycle after each cycle in which `sc_req` was 1.
- R9: A store-conditional and a load-reserve in the same cycle work as follows. The store is judged against the reservation held before that cycle, and the new load-reserve's reservation is what remains afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lr_req | input | 1 | Load-reserve request this cycle |
| lr_addr | input | AW | Effective address of the load-reserve |
| lr_size | input | 2 | Load-reserve size code (0..3 = 1/2/4/8 bytes) |
| sc_req | input | 1 | Store-conditional request this cycle |
| sc_addr | input | AW | Effective address of the store-conditional |
| sc_size | input | 2 | Store-conditional size code |
| sc_so | input | 1 | Current summary-overflow bit |
| resv_clr | input | 1 | External reservation clear |
| sc_done | output | 1 | Result strobe, one cycle after `sc_req` |
| st_wen | output | 1 | Store write-enable (success only) |
| sc_crf | output | 4 | Condition-field result code |
| resv_valid | output | 1 | Reservation held |
| resv_addr | output | AW | Reserved address |
| resv_len | output | 4 | Reserved length in bytes |

## Verification
The hardest situation to reach is a store-conditional that fails while it looks almost right. Two cases matter: the address is correct but the length differs, and the length is correct but the address differs only in low bits. A third case is a store-conditional that shares its cycle with a load-reserve or an external clear. The stimulus table reaches these cases by re-arming the reservation just before each near-miss store. It also places same-cycle load-reserve and clear combinations right after a reservation is known to be held, so each outcome depends on a single priority decision.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

  typedef enum logic [1:0] {
    ACC_BYTE  = 2'd0,
    ACC_HALF  = 2'd1,
    ACC_WORD  = 2'd2,
    ACC_DWORD = 2'd3
  } acc_size_e;

  localparam int unsigned LEN_W = 4;

  // byte length of an access: 1 << size code
  function automatic logic [LEN_W-1:0] size_to_len(acc_size_e s);
    return LEN_W'(1) << s;
  endfunction

  // condition-field layout: [3:2] zero, [1] performed, [0] overflow copy
  function automatic logic [3:0] make_crf(logic performed, logic so);
    return {2'b00, performed, so};
  endfunction

endpackage

// File: rtl/lrsc_rst_sync.sv
module lrsc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/lrsc_resv_reg.sv
module lrsc_resv_reg
  import lrsc_pkg::*;
#(
  parameter int unsigned AW = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           set_i,
  input  logic [AW-1:0]  set_addr_i,
  input  acc_size_e      set_size_i,
  input  logic           drop_i,
  output logic           valid_o,
  output logic [AW-1:0]  addr_o,
  output acc_size_e      size_o
);

  logic          valid_q, valid_d;
  logic [AW-1:0] addr_q, addr_d;
  acc_size_e     size_q, size_d;
  logic          valid_en, rec_en;

  // a new reservation outranks any drop in the same cycle
  always_comb begin
    valid_en = set_i | drop_i;
    rec_en   = set_i;
    valid_d  = set_i;
    addr_d   = set_addr_i;
    size_d   = set_size_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else if (valid_en) begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      size_q <= ACC_BYTE;
    end else if (rec_en) begin
      addr_q <= addr_d;
      size_q <= size_d;
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign size_o  = size_q;

endmodule

// File: rtl/lrsc_sc_judge.sv
module lrsc_sc_judge
  import lrsc_pkg::*;
#(
  parameter int unsigned AW    = 64,
  parameter int unsigned SLICE = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sc_req_i,
  input  logic [AW-1:0]  sc_addr_i,
  input  acc_size_e      sc_size_i,
  input  logic           sc_so_i,
  input  logic           held_valid_i,
  input  logic [AW-1:0]  held_addr_i,
  input  acc_size_e      held_size_i,
  output logic           done_o,
  output logic           wen_o,
  output logic [3:0]     crf_o
);

  localparam int unsigned NSLICE = (AW + SLICE - 1) / SLICE;
  localparam int unsigned PW     = NSLICE * SLICE;

  logic [PW-1:0]     sc_pad, held_pad;
  logic [NSLICE-1:0] slice_eq;
  logic              addr_eq, size_eq, performed;

  assign sc_pad   = PW'(sc_addr_i);
  assign held_pad = PW'(held_addr_i);

  // address compare split into slices so each term stays shallow
  for (genvar g = 0; g < NSLICE; g++) begin : g_cmp
    assign slice_eq[g] = (sc_pad[g*SLICE +: SLICE] == held_pad[g*SLICE +: SLICE]);
  end

  logic          done_d, wen_d;
  logic [3:0]    crf_d;
  logic          done_q, wen_q;
  logic [3:0]    crf_q;

  always_comb begin
    addr_eq   = &slice_eq;
    size_eq   = (sc_size_i == held_size_i);
    performed = held_valid_i & size_eq & addr_eq;
    done_d    = sc_req_i;
    wen_d     = sc_req_i & performed;
    crf_d     = sc_req_i ? make_crf(performed, sc_so_i) : 4'b0000;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      wen_q  <= 1'b0;
      crf_q  <= 4'b0000;
    end else begin
      done_q <= done_d;
      wen_q  <= wen_d;
      crf_q  <= crf_d;
    end
  end

  assign done_o = done_q;
  assign wen_o  = wen_q;
  assign crf_o  = crf_q;

endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
  import lrsc_pkg::*;
#(
  parameter int unsigned AW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lr_req,
  input  logic [AW-1:0] lr_addr,
  input  logic [1:0]    lr_size,
  input  logic          sc_req,
  input  logic [AW-1:0] sc_addr,
  input  logic [1:0]    sc_size,
  input  logic          sc_so,
  input  logic          resv_clr,
  output logic          sc_done,
  output logic          st_wen,
  output logic [3:0]    sc_crf,
  output logic          resv_valid,
  output logic [AW-1:0] resv_addr,
  output logic [3:0]    resv_len
);

  logic          core_rst_n;
  logic          held_valid;
  logic [AW-1:0] held_addr;
  acc_size_e     held_size;

  lrsc_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (core_rst_n)
  );

  lrsc_resv_reg #(.AW(AW)) i_resv (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .set_i      (lr_req),
    .set_addr_i (lr_addr),
    .set_size_i (acc_size_e'(lr_size)),
    .drop_i     (sc_req | resv_clr),
    .valid_o    (held_valid),
    .addr_o     (held_addr),
    .size_o     (held_size)
  );

  lrsc_sc_judge #(.AW(AW), .SLICE(16)) i_judge (
    .clk          (clk),
    .rst_n        (core_rst_n),
    .sc_req_i     (sc_req),
    .sc_addr_i    (sc_addr),
    .sc_size_i    (acc_size_e'(sc_size)),
    .sc_so_i      (sc_so),
    .held_valid_i (held_valid),
    .held_addr_i  (held_addr),
    .held_size_i  (held_size),
    .done_o       (sc_done),
    .wen_o        (st_wen),
    .crf_o        (sc_crf)
  );

  assign resv_valid = held_valid;
  assign resv_addr  = held_addr;
  assign resv_len   = size_to_len(held_size);

endmodule

// File: rtl/lrsc_monitor_chk.sv
module lrsc_monitor_chk #(
  parameter int unsigned AW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lr_req,
  input logic [AW-1:0] lr_addr,
  input logic          sc_req,
  input logic          sc_so,
  input logic          resv_clr,
  input logic          sc_done,
  input logic          st_wen,
  input logic [3:0]    sc_crf,
  input logic          resv_valid,
  input logic [AW-1:0] resv_addr,
  input logic [3:0]    resv_len
);

  p_lr_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lr_req |=> (resv_valid && resv_addr == $past(lr_addr)));

  p_len_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    resv_valid |-> ($countones(resv_len) == 1));

  p_wen_needs_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st_wen |-> sc_done);

  p_no_resv_no_wen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_req && !resv_valid) |=> !st_wen);

  p_crf_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sc_done |-> (sc_crf[3:2] == 2'b00 && sc_crf[1] == st_wen));

  p_crf_so_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sc_req |=> (sc_crf[0] == $past(sc_so)));

  p_sc_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_req && !lr_req) |=> !resv_valid);

  p_clr_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (resv_clr && !lr_req) |=> !resv_valid);

  p_done_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sc_req |=> sc_done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sc_req |=> (!sc_done && sc_crf == 4'b0000));

endmodule

bind lrsc_monitor lrsc_monitor_chk #(.AW(AW)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lr_req     (lr_req),
  .lr_addr    (lr_addr),
  .sc_req     (sc_req),
  .sc_so      (sc_so),
  .resv_clr   (resv_clr),
  .sc_done    (sc_done),
  .st_wen     (st_wen),
  .sc_crf     (sc_crf),
  .resv_valid (resv_valid),
  .resv_addr  (resv_addr),
  .resv_len   (resv_len)
);

// File: tb/test_lrsc_monitor.sv
module test_lrsc_monitor;

  localparam int unsigned AW = 64;

  logic          clk;
  logic          rst_n;
  logic          lr_req;
  logic [AW-1:0] lr_addr;
  logic [1:0]    lr_size;
  logic          sc_req;
  logic [AW-1:0] sc_addr;
  logic [1:0]    sc_size;
  logic          sc_so;
  logic          resv_clr;
  logic          sc_done;
  logic          st_wen;
  logic [3:0]    sc_crf;
  logic          resv_valid;
  logic [AW-1:0] resv_addr;
  logic [3:0]    resv_len;

  int n_cmp = 0;
  int n_bad = 0;
  logic finished = 1'b0;

  lrsc_monitor #(.AW(AW)) i_lrsc_monitor (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  typedef struct packed {
    logic          lr;
    logic [AW-1:0] la;
    logic [1:0]    ls;
    logic          sc;
    logic [AW-1:0] sa;
    logic [1:0]    ss;
    logic          so;
    logic          clr;
    logic          e_wen;
    logic [3:0]    e_crf;
    logic          e_valid;
  } vec_t;

  function automatic vec_t mk(logic lr, logic [AW-1:0] la, logic [1:0] ls,
                              logic sc, logic [AW-1:0] sa, logic [1:0] ss,
                              logic so, logic clr, logic e_wen,
                              logic [3:0] e_crf, logic e_valid);
    vec_t v;
    v = '{lr, la, ls, sc, sa, ss, so, clr, e_wen, e_crf, e_valid};
    return v;
  endfunction

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    mk(1, 64'h1000, 2, 0, 0,        0, 0, 0, 0, 4'b0000, 1), // arm word
    mk(0, 0,        0, 1, 64'h1000, 2, 0, 0, 1, 4'b0010, 0), // exact hit
    mk(0, 0,        0, 1, 64'h1000, 2, 1, 0, 0, 4'b0001, 0), // consumed
    mk(1, 64'h2008, 3, 0, 0,        0, 0, 0, 0, 4'b0000, 1),
    mk(0, 0,        0, 1, 64'h2008, 2, 0, 0, 0, 4'b0000, 0), // length miss
    mk(1, 64'h2008, 3, 0, 0,        0, 0, 0, 0, 4'b0000, 1),
    mk(0, 0,        0, 1, 64'h2000, 3, 1, 0, 0, 4'b0001, 0), // address miss
    mk(1, 64'h0030, 0, 0, 0,        0, 0, 0, 0, 4'b0000, 1),
    mk(1, 64'h0040, 1, 0, 0,        0, 0, 0, 0, 4'b0000, 1), // overwrite
    mk(0, 0,        0, 1, 64'h0030, 0, 0, 0, 0, 4'b0000, 0), // stale addr
    mk(1, 64'h0040, 1, 0, 0,        0, 0, 0, 0, 4'b0000, 1),
    mk(0, 0,        0, 1, 64'h0040, 1, 1, 0, 1, 4'b0011, 0), // hit + so
    mk(1, 64'h0050, 0, 0, 0,        0, 0, 0, 0, 4'b0000, 1),
    mk(0, 0,        0, 0, 0,        0, 0, 1, 0, 4'b0000, 0), // external clear
    mk(0, 0,        0, 1, 64'h0050, 0, 0, 0, 0, 4'b0000, 0),
    mk(1, 64'h0060, 2, 0, 0,        0, 0, 1, 0, 4'b0000, 1), // lr beats clear
    mk(0, 0,        0, 1, 64'h0060, 2, 0, 0, 1, 4'b0010, 0),
    mk(1, 64'h0070, 3, 0, 0,        0, 0, 0, 0, 4'b0000, 1),
    mk(1, 64'h0080, 0, 1, 64'h0070, 3, 0, 0, 1, 4'b0010, 1), // sc+lr same cycle
    mk(0, 0,        0, 1, 64'h0080, 0, 0, 0, 1, 4'b0010, 0)
  };

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    lr_req = 0; lr_addr = '0; lr_size = 0;
    sc_req = 0; sc_addr = '0; sc_size = 0; sc_so = 0; resv_clr = 0;
  endtask

  // apply one vector for one cycle; called at a falling edge
  task automatic apply(input vec_t v);
    lr_req = v.lr; lr_addr = v.la; lr_size = v.ls;
    sc_req = v.sc; sc_addr = v.sa; sc_size = v.ss; sc_so = v.so;
    resv_clr = v.clr;
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1: state held in reset
    chk("R1", "resv_valid", resv_valid, 0);
    chk("R1", "sc_done", sc_done, 0);
    chk("R1", "st_wen", st_wen, 0);
    chk("R1", "sc_crf", sc_crf, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: store-conditional with no prior load-reserve fails
    apply(mk(0, 0, 0, 1, 64'h0, 0, 0, 0, 0, 0, 0));
    chk("R1", "st_wen", st_wen, 0);
    chk("R1", "sc_crf", sc_crf, 4'b0000);
    chk("R8", "sc_done", sc_done, 1);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string rq;
      v = TBL[i];
      apply(v);
      rq = v.clr ? "R7" : (v.sc && v.lr) ? "R9" : v.sc ? "R5" : "R2";
      chk("R8", "sc_done", sc_done, v.sc);
      chk("R3", "st_wen", st_wen, v.e_wen);
      chk("R4", "sc_crf", sc_crf, v.e_crf);
      chk(rq, "resv_valid", resv_valid, v.e_valid);
      if (v.lr) begin
        chk("R2", "resv_addr", resv_addr, v.la);
        chk("R2", "resv_len", resv_len, 64'(4'b0001 << v.ls));
      end
    end

    // R6: second load-reserve replaces the first
    apply(mk(1, 64'hA000, 3, 0, 0, 0, 0, 0, 0, 0, 0));
    apply(mk(1, 64'hB004, 2, 0, 0, 0, 0, 0, 0, 0, 0));
    chk("R6", "resv_addr", resv_addr, 64'hB004);
    chk("R6", "resv_len", resv_len, 4);
    apply(mk(0, 0, 0, 1, 64'hA000, 3, 0, 0, 0, 0, 0));
    chk("R6", "st_wen", st_wen, 0);
    chk("R5", "resv_valid", resv_valid, 0);

    // R8: strobe drops the cycle after
    @(negedge clk);
    chk("R8", "sc_done", sc_done, 0);
    chk("R4", "sc_crf idle", sc_crf, 0);

    // R1: reset drops a held reservation
    apply(mk(1, 64'hC000, 1, 0, 0, 0, 0, 0, 0, 0, 0));
    chk("R2", "resv_valid", resv_valid, 1);
    rst_n = 0;
    @(negedge clk);
    chk("R1", "resv_valid", resv_valid, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    apply(mk(0, 0, 0, 1, 64'hC000, 1, 0, 0, 0, 0, 0));
    chk("R1", "st_wen", st_wen, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule